// File: doc/BRIEF.md
# I2C Master Byte Receiver with Per-Byte Wait

This block is the receive engine of an I2C master. After a short start sequence it clocks in bytes from a slave, one after another. It samples SDA on every rising SCL edge, most significant bit first, and latches each finished byte into a receive register. On the ninth clock of each byte it acknowledges the byte, or it sends a not-acknowledge when the final byte has been marked. On a software command it finishes the transfer with a stop condition. Both bus lines are open-drain: the block only pulls them low or lets them go.

Software controls the engine through a few level and pulse inputs. When wait mode is on, the engine raises its event flag at the falling edge of the eighth data clock. It then holds SCL low until software clears the flag, which gives the processor time to read the byte and choose the acknowledge value. When wait mode is off, the flag rises with the ninth clock and the bus keeps running. The interrupt output is the flag gated by an enable bit. A byte that is not acknowledged parks the engine with SCL low. A stop command is honoured only while the engine is parked. To end a transfer correctly in wait mode, software turns wait mode off, then clears the flag, then issues the stop command. If software clears the flag while wait mode is still on, the park is taken as a released wait and another byte is clocked in.

The length of each SCL phase comes from a divider input. The high phase and the low phase each last `half_per`+1 system clocks.

Top module: `i2c_mrx_wait`

## Requirements
- R1: SDA is sampled at the end of each SCL low phase, in the cycle before SCL is released. The first bit is the most significant. The full byte appears on `rx_data_o` when the eighth bit is taken, and `rx_data_o` changes at no other time.
- R2: Each SCL low phase and each SCL high phase generated by the block lasts exactly `half_per`+1 clock cycles.
- R3: With `wait_en`=1, `flag_o` rises in the same cycle that SCL is pulled low after the eighth data clock. SCL then stays low for as long as the flag remains set.
- R4: During the ninth (acknowledge) clock of a byte, SDA is pulled low if `ack_ctl` was 0 when the ninth clock's low phase began.
- R5: If `ack_ctl` was 1 at that point, SDA is released during the ninth clock. After that clock the engine parks, with SCL held low, `busy_o`=1 and no further clocks.
- R6: With `wait_en`=0, `flag_o` does not rise at the eighth clock. It rises in the cycle SCL is released for the ninth clock.
- R7: With `wait_en`=1 and a not-acknowledged byte, `flag_o` rises a second time, when SCL is released for the ninth clock.
- R8: After an acknowledged ninth clock, the next byte is clocked without any software action, even while `flag_o` is still set.
- R9: A `stop_cmd` pulse while parked produces a stop condition in three steps. First SDA is pulled low with SCL low. Then SCL is released. Then SDA is released while SCL is high, after which `busy_o` returns to 0.
- R10: A `stop_cmd` pulse at any time other than the parked state has no effect. A `flag_clr` pulse while parked with `wait_en`=1 releases the engine into another byte instead of allowing a stop.
- R11: `irq_o` is 1 exactly when `flag_o` is 1 and `irq_en` is 1. When both are set in the same cycle, a flag set takes priority over `flag_clr`.
- R12: After reset all outputs are 0. A `start_cmd` pulse while idle pulls SDA low with SCL released for one phase, then starts the first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_per | input | DIV_W | SCL phase length minus one, in clock cycles |
| start_cmd | input | 1 | Pulse: begin a receive transfer from idle |
| stop_cmd | input | 1 | Pulse: generate a stop condition from the parked state |
| wait_en | input | 1 | 1 = hold SCL low after the eighth clock until the flag is cleared |
| ack_ctl | input | 1 | Acknowledge value for the ninth clock: 0 = ACK, 1 = NACK |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Pulse: clear the event flag |
| sda_i | input | 1 | Sensed SDA line level |
| scl_low_o | output | 1 | 1 = pull SCL low, 0 = release |
| sda_low_o | output | 1 | 1 = pull SDA low, 0 = release |
| rx_data_o | output | DATA_W | Last completed received byte |
| flag_o | output | 1 | Event flag |
| irq_o | output | 1 | Interrupt request |
| busy_o | output | 1 | Transfer in progress |

## Verification
The hardest condition to reach is the release-ordering case. The engine has to be parked after a not-acknowledged byte with wait mode still on, and then the flag is cleared before wait mode is turned off. The stimulus gets there by running a wait-mode byte with `ack_ctl` set and waiting for the second flag at the ninth clock. It then pulses the clear with `wait_en` still high, and sends a stop command while the resumed byte is being clocked, which must be ignored. A behavioural model in the bench tracks every half-phase of SCL and is compared with the bus outputs and the flag on every clock. This comparison also covers the long wait holds and the second flag at the ninth clock.

// File: rtl/i2c_mrx_pkg.sv
`timescale 1ns/1ps
package i2c_mrx_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_WAIT8,
        ST_ACK_LO,
        ST_ACK_HI,
        ST_PARK,
        ST_STOP_LO,
        ST_STOP_HI
    } mrx_state_e;
endpackage

// File: rtl/i2c_mrx_tick.sv
`timescale 1ns/1ps
// Phase timer: pulses tick at the last cycle of each SCL half period.
module i2c_mrx_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_per,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_s;

    tick_s t_d, t_q;

    always_comb begin
        tick  = run && (t_q.cnt == half_per);
        t_d   = t_q;
        if (!run || tick) t_d.cnt = '0;
        else              t_d.cnt = t_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/i2c_mrx_shreg.sv
`timescale 1ns/1ps
// Receive shifter: collects bits MSB first and publishes the full byte.
module i2c_mrx_shreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              last,
    input  logic              sda_i,
    output logic [DATA_W-1:0] rx_data
);
    typedef struct packed {
        logic [DATA_W-2:0] sh;
        logic [DATA_W-1:0] rx;
    } sh_s;

    sh_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (sample) begin
            s_d.sh = {s_q.sh[DATA_W-3:0], sda_i};
            if (last) s_d.rx = {s_q.sh, sda_i};
        end
        rx_data = s_q.rx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/i2c_mrx_ctrl.sv
`timescale 1ns/1ps
// Bus sequencer: start, eight data clocks, optional wait, ack clock, park, stop.
module i2c_mrx_ctrl
    import i2c_mrx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start_cmd,
    input  logic stop_cmd,
    input  logic wait_en,
    input  logic ack_ctl,
    input  logic flag_clr,
    output logic run,
    output logic sample,
    output logic last,
    output logic scl_low,
    output logic sda_low,
    output logic flag,
    output logic busy
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(DATA_W - 1);

    typedef struct packed {
        mrx_state_e       st;
        logic [BIT_W-1:0] bitn;
        logic             flag;
        logic             nack;
    } ctrl_s;

    ctrl_s c_d, c_q;
    logic  set_flag;

    always_comb begin
        c_d      = c_q;
        set_flag = 1'b0;
        case (c_q.st)
            ST_IDLE: if (start_cmd) c_d.st = ST_START;
            ST_START: if (tick) begin
                c_d.st   = ST_BIT_LO;
                c_d.bitn = TOP_BIT;
            end
            ST_BIT_LO: if (tick) c_d.st = ST_BIT_HI;
            ST_BIT_HI: if (tick) begin
                if (c_q.bitn != '0) begin
                    c_d.bitn = c_q.bitn - 1'b1;
                    c_d.st   = ST_BIT_LO;
                end else if (wait_en) begin
                    c_d.st   = ST_WAIT8;
                    set_flag = 1'b1;
                end else begin
                    c_d.st   = ST_ACK_LO;
                    c_d.nack = ack_ctl;
                end
            end
            ST_WAIT8: if (!c_q.flag) begin
                c_d.st   = ST_ACK_LO;
                c_d.nack = ack_ctl;
            end
            ST_ACK_LO: if (tick) begin
                c_d.st   = ST_ACK_HI;
                set_flag = !wait_en || c_q.nack;
            end
            ST_ACK_HI: if (tick) begin
                if (c_q.nack) c_d.st = ST_PARK;
                else begin
                    c_d.st   = ST_BIT_LO;
                    c_d.bitn = TOP_BIT;
                end
            end
            ST_PARK: begin
                if (stop_cmd) c_d.st = ST_STOP_LO;
                else if (flag_clr && wait_en) begin
                    c_d.st   = ST_BIT_LO;
                    c_d.bitn = TOP_BIT;
                end
            end
            ST_STOP_LO: if (tick) c_d.st = ST_STOP_HI;
            ST_STOP_HI: if (tick) c_d.st = ST_IDLE;
            default:    c_d.st = ST_IDLE;
        endcase

        if (set_flag)      c_d.flag = 1'b1;
        else if (flag_clr) c_d.flag = 1'b0;

        run = (c_q.st == ST_START)   || (c_q.st == ST_BIT_LO) || (c_q.st == ST_BIT_HI) ||
              (c_q.st == ST_ACK_LO)  || (c_q.st == ST_ACK_HI) ||
              (c_q.st == ST_STOP_LO) || (c_q.st == ST_STOP_HI);
        sample  = (c_q.st == ST_BIT_LO) && tick;
        last    = (c_q.bitn == '0);
        scl_low = (c_q.st == ST_BIT_LO) || (c_q.st == ST_WAIT8) || (c_q.st == ST_ACK_LO) ||
                  (c_q.st == ST_PARK)   || (c_q.st == ST_STOP_LO);
        sda_low = (c_q.st == ST_START)  || (c_q.st == ST_STOP_LO) || (c_q.st == ST_STOP_HI) ||
                  (((c_q.st == ST_ACK_LO) || (c_q.st == ST_ACK_HI)) && !c_q.nack);
        flag    = c_q.flag;
        busy    = (c_q.st != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, bitn: '0, flag: 1'b0, nack: 1'b0};
        else        c_q <= c_d;
    end

    // R3: a cleared flag in the wait state lets the ninth clock begin
    a_r3_wait_release: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_WAIT8 && !c_q.flag) |=> (c_q.st == ST_ACK_LO));

    // R5: the end of a not-acknowledged ninth clock parks the engine
    a_r5_nack_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_ACK_HI && c_q.nack && tick) |=> (c_q.st == ST_PARK));

    // R9: a stop sequence only ever begins from the parked state
    a_r9_stop_from_park: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.st == ST_STOP_LO) |-> ($past(c_q.st) == ST_PARK));
endmodule

// File: rtl/i2c_mrx_wait.sv
`timescale 1ns/1ps
module i2c_mrx_wait #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  half_per,
    input  logic              start_cmd,
    input  logic              stop_cmd,
    input  logic              wait_en,
    input  logic              ack_ctl,
    input  logic              irq_en,
    input  logic              flag_clr,
    input  logic              sda_i,
    output logic              scl_low_o,
    output logic              sda_low_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              flag_o,
    output logic              irq_o,
    output logic              busy_o
);
    logic tick, run, sample, last;

    i2c_mrx_tick #(.DIV_W(DIV_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .run(run), .half_per(half_per), .tick(tick)
    );

    i2c_mrx_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .start_cmd(start_cmd), .stop_cmd(stop_cmd), .wait_en(wait_en),
        .ack_ctl(ack_ctl), .flag_clr(flag_clr),
        .run(run), .sample(sample), .last(last),
        .scl_low(scl_low_o), .sda_low(sda_low_o), .flag(flag_o), .busy(busy_o)
    );

    i2c_mrx_shreg #(.DATA_W(DATA_W)) shreg_i (
        .clk(clk), .rst_n(rst_n), .sample(sample), .last(last),
        .sda_i(sda_i), .rx_data(rx_data_o)
    );

    assign irq_o = flag_o & irq_en;

    // R2: the phase timer only fires while the sequencer is clocking
    a_r2_tick_while_run: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);

    // R1: the receive register moves only on the eighth sample
    a_r1_rx_update_point: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data_o) |-> $past(sample && last));

    // R6: without wait, a new flag coincides with SCL released
    a_r6_flag_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_o) && !$past(wait_en)) |-> !scl_low_o);
endmodule

// File: tb/i2c_mrx_wait_tb_top.sv
`timescale 1ns/1ps
module i2c_mrx_wait_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] half_per = 8'd3;
    logic       start_cmd = 0, stop_cmd = 0, wait_en = 0, ack_ctl = 0;
    logic       irq_en = 0, flag_clr = 0;
    logic       slave_sda = 1'b1;
    logic       scl_low_o, sda_low_o, flag_o, irq_o, busy_o;
    logic [7:0] rx_data_o;

    always #2 clk = ~clk;

    i2c_mrx_wait dut_i (
        .clk(clk), .rst_n(rst_n), .half_per(half_per),
        .start_cmd(start_cmd), .stop_cmd(stop_cmd), .wait_en(wait_en),
        .ack_ctl(ack_ctl), .irq_en(irq_en), .flag_clr(flag_clr),
        .sda_i(slave_sda), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
        .rx_data_o(rx_data_o), .flag_o(flag_o), .irq_o(irq_o), .busy_o(busy_o)
    );

    int checks = 0, errors = 0, cyc = 0, stops = 0;
    logic [7:0] tx [16];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural model: md 0 idle,1 start,2 byte,3 wait,4 park,5 stop; h = half phase
    int md = 0, h = 0, cnt = 0, nb = -1;
    logic [7:0] m_sh = 0, m_rx = 0;
    logic m_fl = 0, m_nk = 0, m_run, m_tk, m_set;

    always @(posedge clk) begin
        if (!rst_n) begin
            md = 0; h = 0; cnt = 0; nb = -1; m_sh = 0; m_rx = 0; m_fl = 0; m_nk = 0;
        end else begin
            m_run = (md == 1) || (md == 2) || (md == 5);
            m_tk  = m_run && (cnt == int'(half_per));
            m_set = 0;
            cnt   = (m_run && !m_tk) ? cnt + 1 : 0;
            case (md)
                0: if (start_cmd) md = 1;
                1: if (m_tk) begin md = 2; h = 0; nb++; end
                2: if (m_tk) begin
                    if (h == 17) begin
                        if (m_nk) md = 4; else begin h = 0; nb++; end
                    end else if (h == 16) begin
                        h = 17; if (!wait_en || m_nk) m_set = 1;
                    end else if (h == 15) begin
                        if (wait_en) begin md = 3; m_set = 1; end
                        else begin h = 16; m_nk = ack_ctl; end
                    end else begin
                        if (h % 2 == 0) begin
                            m_sh = {m_sh[6:0], slave_sda};
                            if (h == 14) m_rx = m_sh;
                        end
                        h++;
                    end
                end
                3: if (!m_fl) begin md = 2; h = 16; m_nk = ack_ctl; end
                4: if (stop_cmd) begin md = 5; h = 0; end
                   else if (flag_clr && wait_en) begin md = 2; h = 0; nb++; end
                5: if (m_tk) begin if (h == 1) md = 0; else h = 1; end
                default: md = 0;
            endcase
            if (m_set) m_fl = 1; else if (flag_clr) m_fl = 0;
        end
    end

    // Slave: presents the byte bit for the current low phase
    always @(negedge clk)
        slave_sda <= (md == 2 && h < 16 && nb >= 0) ? tx[nb % 16][7 - (h / 2)] : 1'b1;

    // Per-clock comparison and stop monitor, sampled 1 ns after the edge
    logic p_scl = 0, p_sda = 0;
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            chk(scl_low_o == ((md == 2 && h % 2 == 0) || md == 3 || md == 4 || (md == 5 && h == 0)),
                "R2", "scl_low", scl_low_o, !scl_low_o);
            chk(sda_low_o == (md == 1 || md == 5 || (md == 2 && h >= 16 && !m_nk)),
                "R4", "sda_low", sda_low_o, !sda_low_o);
            chk(flag_o == m_fl, "R6", "flag", flag_o, m_fl);
            chk(irq_o == (m_fl && irq_en), "R11", "irq", irq_o, m_fl && irq_en);
            chk(rx_data_o == m_rx, "R1", "rx_data", rx_data_o, m_rx);
            chk(busy_o == (md != 0), "R12", "busy", busy_o, md != 0);
            if (p_sda && !sda_low_o && !p_scl && !scl_low_o) stops++;
        end
        p_scl = scl_low_o;
        p_sda = sda_low_o;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 100000) begin
            errors++;
            $display("FAIL watchdog all requirements actual=hang expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic pulse_start(); @(negedge clk) start_cmd = 1; @(negedge clk) start_cmd = 0; endtask
    task automatic pulse_stop();  @(negedge clk) stop_cmd = 1;  @(negedge clk) stop_cmd = 0;  endtask
    task automatic pulse_clr();   @(negedge clk) flag_clr = 1;  @(negedge clk) flag_clr = 0;  endtask

    task automatic wait_flag(input string req);
        int n = 0;
        while (!flag_o && n < 3000) begin @(negedge clk); n++; end
        chk(flag_o, req, "flag timeout", flag_o, 1);
    endtask

    task automatic wait_scl(input logic lvl);
        int n = 0;
        while (scl_low_o != lvl && n < 3000) begin @(negedge clk); n++; end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy_o && n < 3000) begin @(negedge clk); n++; end
    endtask

    initial begin
        tx = '{8'hA5, 8'h3C, 8'h96, 8'h01, 8'hFF, 8'h00, 8'h5A, 8'h5A,
               8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A};
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk(!scl_low_o && !sda_low_o && !flag_o && !irq_o && !busy_o && rx_data_o == 0,
            "R12", "reset outputs", {scl_low_o, sda_low_o, flag_o, irq_o, busy_o}, 0);

        // Scenario 1: wait off, interrupts on
        half_per = 8'd3; wait_en = 0; irq_en = 1; ack_ctl = 0;
        pulse_start();
        chk(sda_low_o && !scl_low_o, "R12", "start: SDA low, SCL high",
            {sda_low_o, scl_low_o}, 2'b10);
        repeat (3) @(negedge clk);
        pulse_stop();                              // R10: ignored mid-transfer
        wait_flag("R6");
        chk(rx_data_o == 8'hA5, "R1", "first byte", rx_data_o, 8'hA5);
        chk(!scl_low_o && sda_low_o, "R6", "flag at 9th high with ACK (R4)",
            {scl_low_o, sda_low_o}, 2'b01);
        chk(irq_o, "R11", "irq with enable", irq_o, 1);
        chk(busy_o && stops == 0, "R10", "stop outside park ignored", stops, 0);
        @(negedge clk) ack_ctl = 1;
        wait_scl(1'b1);
        wait_scl(1'b0);
        chk(flag_o && busy_o, "R8", "next byte clocks with flag pending", flag_o, 1);
        pulse_clr();
        wait_flag("R5");
        chk(rx_data_o == 8'h3C, "R1", "second byte", rx_data_o, 8'h3C);
        chk(!sda_low_o, "R5", "NACK releases SDA", sda_low_o, 0);
        repeat (12) @(negedge clk);
        chk(scl_low_o && busy_o, "R5", "parked with SCL low", {scl_low_o, busy_o}, 2'b11);
        pulse_stop();
        wait_idle();
        chk(stops == 1 && !busy_o, "R9", "stop generated", stops, 1);
        pulse_clr();

        // Scenario 2: wait on, interrupts off
        half_per = 8'd2; wait_en = 1; irq_en = 0; ack_ctl = 0;
        pulse_start();
        wait_flag("R3");
        chk(scl_low_o, "R3", "flag at 8th fall", scl_low_o, 1);
        chk(rx_data_o == 8'h96, "R1", "wait byte", rx_data_o, 8'h96);
        chk(!irq_o, "R11", "irq masked", irq_o, 0);
        begin
            bit held = 1;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (!scl_low_o || !flag_o) held = 0;
            end
            chk(held, "R3", "SCL held while flag set", held, 1);
        end
        pulse_clr();
        wait_flag("R3");
        chk(rx_data_o == 8'h01, "R1", "final wait byte", rx_data_o, 8'h01);
        @(negedge clk) ack_ctl = 1;
        pulse_clr();
        wait_flag("R7");
        chk(!scl_low_o && !sda_low_o, "R7", "second flag at NACK 9th high",
            {scl_low_o, sda_low_o}, 2'b00);
        @(negedge clk) wait_en = 0;
        pulse_clr();
        pulse_stop();
        wait_idle();
        chk(stops == 2, "R9", "stop after correct release order", stops, 2);

        // Scenario 3: wrong release order in park
        half_per = 8'd1; wait_en = 1; ack_ctl = 1;
        pulse_start();
        wait_flag("R3");
        pulse_clr();
        wait_flag("R7");
        repeat (6) @(negedge clk);
        chk(scl_low_o && flag_o, "R5", "parked awaiting software", {scl_low_o, flag_o}, 2'b11);
        pulse_clr();                               // wait still on: resumes
        wait_scl(1'b0);
        chk(busy_o && !scl_low_o, "R10", "clear in park with wait resumes", scl_low_o, 0);
        pulse_stop();                              // ignored mid-byte
        wait_flag("R3");
        chk(stops == 2, "R10", "stop during resumed byte ignored", stops, 2);
        chk(rx_data_o == 8'h00, "R1", "resumed byte", rx_data_o, 8'h00);
        pulse_clr();
        wait_flag("R7");
        @(negedge clk) wait_en = 0;
        pulse_clr();
        pulse_stop();
        wait_idle();
        chk(stops == 3 && !busy_o, "R9", "final stop", stops, 3);

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule